// File: doc/BRIEF.md
# Serial Configuration Loader

This block loads a configuration image into a programmable target device through the target's serial slave configuration port. One start pulse sets off a fixed sequence. The block first holds the target in reset with chip select low. It then releases reset and waits while the target clears its configuration memory. Next it checks that the target's done flag is low. After that it sends a short burst of idle clocks with chip select high.

Once those steps are complete, the block drops chip select and streams the whole image as SPI mode 0, most significant bit first. The image comes in as a byte stream with valid, ready and a last flag. It must arrive without a break.

When the last byte has gone out, the block raises chip select and sends trailing idle clocks, then checks the done flag again. If the flag is high, it sends a final run of idle clocks so the target can bring up its user I/O, and only then reports success. Any failure stops the run and holds a two-bit error code. The code tells a stalled stream apart from a failed reset handshake and from a failed configuration.

All times come from a clock-frequency parameter. Each count is rounded up so that the minimum times always hold.

Top module: `cfg_loader`

## Requirements
- R1: After reset, and whenever no run is active, target reset and chip select are both high (released), SCLK is low, `img_ready_o` is low, and `busy_o` is high only while a run is active.
- R2: A start pulse drives target reset and chip select low together. Reset stays low for ceil(RST_NS·CLK_HZ/1e9) clock cycles and is then released while chip select is still low.
- R3: After reset is released, chip select stays low and no SCLK edge occurs for at least ceil(CLEAR_NS·CLK_HZ/1e9) cycles before the first done check.
- R4: If the synchronised done input reads high at that check, the run ends with error code 2 (handshake). No SCLK edge is issued in the whole run, and chip select is raised.
- R5: After a low done check, chip select goes high and 8·PRE_BYTES SCLK rising edges are sent with MOSI low.
- R6: The image is then sent in a single chip-select-low period, mode 0 (SCLK idles low, MOSI is stable at each rising edge), MSB first. Chip select changes only while the shifter is idle. Chip select goes low exactly twice per run (reset and image), or once if the run ends at the first check.
- R7: After the last image byte, chip select goes high and 8·POST_BYTES SCLK rising edges (104 by default) are sent with MOSI low.
- R8: If done then reads low, the run ends with error code 3 (done status). `ok_o` stays low and no further SCLK edges are sent.
- R9: If done reads high, a further 8·ACT_BYTES rising edges (104 by default) are sent with MOSI low. `ok_o` then rises in the same cycle as `busy_o` falls.
- R10: If `img_valid_i` is low when the shifter needs the next image byte (the first byte included), the run ends with error code 1 (communication). Chip select goes high and no more SCLK edges are sent.
- R11: `ok_o` and `err_o` stay unchanged until the next accepted start, which clears both. `ok_o` and a nonzero `err_o` are never high together. A start pulse during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| img_data_i | input | 8 | Image byte |
| img_valid_i | input | 1 | Image byte valid |
| img_last_i | input | 1 | Marks the final image byte |
| img_ready_o | output | 1 | Image byte accepted this cycle |
| cfg_rst_no | output | 1 | Target reset, active low |
| cfg_cs_no | output | 1 | Target chip select, active low |
| cfg_sclk_o | output | 1 | SPI clock, idles low |
| cfg_mosi_o | output | 1 | SPI data to target |
| cfg_done_i | input | 1 | Target done flag, asynchronous |
| busy_o | output | 1 | Run in progress |
| ok_o | output | 1 | Last run succeeded |
| err_o | output | 2 | Last run error: 0 none, 1 comm, 2 handshake, 3 done status |

## Verification
A sequencer that is one state off shows up at the target pins: the count of SCLK rising edges in a chip-select phase changes by multiples of eight, or chip select falls a third time. This is visible within one byte time of the fault. A shifter fault shows up as wrong image bytes rebuilt from MOSI at SCLK rising edges, on the first affected byte. A counter or rounding error changes the measured reset-low or clear-wait lengths by at least a cycle. A mis-decoded done check shows up as the wrong error code and the wrong trailing clock count as soon as the run ends.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RST, ST_CLR, ST_CHK_RST, ST_PRE, ST_IMG, ST_POST, ST_CHK_CFG, ST_ACT
  } st_e;

  typedef enum logic [1:0] {
    E_NONE = 2'd0, E_COMM = 2'd1, E_PIN = 2'd2, E_DONE = 2'd3
  } err_e;

  function automatic longint unsigned cdiv(longint unsigned a, longint unsigned b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] ff_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= 2'b00;
    else         ff_q <= {ff_q[0], d_i};
  end
  assign q_o = ff_q[1];
endmodule

// File: rtl/cfg_spi_shift.sv
module cfg_spi_shift #(
  parameter int unsigned HALF = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ld_i,
  input  logic [7:0] ld_data_i,
  output logic       rdy_o,
  output logic       active_o,
  output logic       sclk_o,
  output logic       mosi_o
);
  localparam int unsigned HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [HW-1:0] H_LAST = HW'(HALF - 1);

  logic [HW-1:0] hcnt_q;
  logic [7:0]    sh_q;
  logic [2:0]    bit_q;
  logic          act_q, sclk_q, tick, byte_end;

  assign tick     = act_q && (hcnt_q == H_LAST);
  assign byte_end = tick && sclk_q && (bit_q == 3'd7);
  assign rdy_o    = !act_q || byte_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0; sh_q <= '0; bit_q <= '0; act_q <= 1'b0; sclk_q <= 1'b0;
    end else if (!act_q) begin
      if (ld_i) begin
        act_q <= 1'b1; sh_q <= ld_data_i; bit_q <= '0; hcnt_q <= '0; sclk_q <= 1'b0;
      end
    end else begin
      hcnt_q <= tick ? '0 : hcnt_q + 1'b1;
      if (tick) begin
        if (!sclk_q) sclk_q <= 1'b1;
        else begin
          sclk_q <= 1'b0;
          if (bit_q == 3'd7) begin
            // back-to-back reload keeps SCLK continuous
            if (ld_i) begin sh_q <= ld_data_i; bit_q <= '0; end
            else act_q <= 1'b0;
          end else begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= {sh_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign active_o = act_q;
  assign sclk_o   = sclk_q;
  assign mosi_o   = sh_q[7];

  // R6
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |-> !sclk_q);
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 125_000_000,
  parameter int unsigned SCLK_HZ    = 25_000_000,
  parameter int unsigned RST_NS     = 200,
  parameter int unsigned CLEAR_NS   = 1_200_000,
  parameter int unsigned PRE_BYTES  = 1,
  parameter int unsigned POST_BYTES = 13,
  parameter int unsigned ACT_BYTES  = 13
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] img_data_i,
  input  logic       img_valid_i,
  input  logic       img_last_i,
  output logic       img_ready_o,
  output logic       cfg_rst_no,
  output logic       cfg_cs_no,
  output logic       cfg_sclk_o,
  output logic       cfg_mosi_o,
  input  logic       cfg_done_i,
  output logic       busy_o,
  output logic       ok_o,
  output logic [1:0] err_o
);
  localparam longint unsigned NS_PER_S = 64'd1_000_000_000;
  localparam int unsigned HALF_R  = int'(cdiv(longint'(CLK_HZ), 2 * longint'(SCLK_HZ)));
  localparam int unsigned HALF    = (HALF_R < 1) ? 1 : HALF_R;
  localparam int unsigned RST_R   = int'(cdiv(longint'(RST_NS) * CLK_HZ, NS_PER_S));
  localparam int unsigned RST_CYC = (RST_R < 1) ? 1 : RST_R;
  localparam int unsigned CLR_R   = int'(cdiv(longint'(CLEAR_NS) * CLK_HZ, NS_PER_S));
  localparam int unsigned CLR_CYC = (CLR_R < 1) ? 1 : CLR_R;
  localparam int unsigned CNT_MAX = (RST_CYC > CLR_CYC) ? RST_CYC : CLR_CYC;
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);
  localparam int unsigned B_MAX   = (POST_BYTES > ACT_BYTES ? POST_BYTES : ACT_BYTES) + PRE_BYTES;
  localparam int unsigned DW      = $clog2(B_MAX + 1);
  localparam logic [CW-1:0] RST_LAST = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] CLR_LAST = CW'(CLR_CYC - 1);

  st_e          st_q;
  err_e         err_q;
  logic         ok_q, got_last_q, done_s;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] dcnt_q;
  logic         sh_ld, sh_rdy, sh_act, dummy_st, img_ld;
  logic [7:0]   sh_data;

  cfg_sync2 u_done_sync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(cfg_done_i), .q_o(done_s));

  assign dummy_st    = (st_q == ST_PRE) || (st_q == ST_POST) || (st_q == ST_ACT);
  assign img_ready_o = (st_q == ST_IMG) && !got_last_q && sh_rdy;
  assign img_ld      = img_ready_o && img_valid_i;
  assign sh_ld       = img_ld || (dummy_st && (dcnt_q != '0) && sh_rdy);
  assign sh_data     = img_ld ? img_data_i : 8'h00;

  cfg_spi_shift #(.HALF(HALF)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(sh_ld), .ld_data_i(sh_data),
    .rdy_o(sh_rdy), .active_o(sh_act), .sclk_o(cfg_sclk_o), .mosi_o(cfg_mosi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; err_q <= E_NONE; ok_q <= 1'b0;
      cnt_q <= '0; dcnt_q <= '0; got_last_q <= 1'b0;
    end else begin
      if (dummy_st && sh_ld) dcnt_q <= dcnt_q - 1'b1;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q <= ST_RST; cnt_q <= '0; ok_q <= 1'b0; err_q <= E_NONE;
        end
        ST_RST: if (cnt_q == RST_LAST) begin cnt_q <= '0; st_q <= ST_CLR; end
                else cnt_q <= cnt_q + 1'b1;
        ST_CLR: if (cnt_q == CLR_LAST) st_q <= ST_CHK_RST;
                else cnt_q <= cnt_q + 1'b1;
        ST_CHK_RST: if (done_s) begin err_q <= E_PIN; st_q <= ST_IDLE; end
                    else begin dcnt_q <= DW'(PRE_BYTES); st_q <= ST_PRE; end
        ST_PRE: if (dcnt_q == '0 && !sh_act) begin got_last_q <= 1'b0; st_q <= ST_IMG; end
        ST_IMG: begin
          if (!got_last_q && sh_rdy) begin
            if (img_valid_i) got_last_q <= img_last_i;
            else begin err_q <= E_COMM; st_q <= ST_IDLE; end
          end
          if (got_last_q && !sh_act) begin dcnt_q <= DW'(POST_BYTES); st_q <= ST_POST; end
        end
        ST_POST: if (dcnt_q == '0 && !sh_act) st_q <= ST_CHK_CFG;
        ST_CHK_CFG: if (done_s) begin dcnt_q <= DW'(ACT_BYTES); st_q <= ST_ACT; end
                    else begin err_q <= E_DONE; st_q <= ST_IDLE; end
        ST_ACT: if (dcnt_q == '0 && !sh_act) begin ok_q <= 1'b1; st_q <= ST_IDLE; end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cfg_rst_no = (st_q != ST_RST);
  assign cfg_cs_no  = !((st_q == ST_RST) || (st_q == ST_CLR) ||
                        (st_q == ST_CHK_RST) || (st_q == ST_IMG));
  assign busy_o     = (st_q != ST_IDLE);
  assign ok_o       = ok_q;
  assign err_o      = err_q;

  // R2
  rst_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_rst_no) |-> !cfg_cs_no);
  // R6
  cs_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_cs_no) |-> !sh_act);
  // R11
  ok_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> (err_o == 2'd0));
  // R9
  ok_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_o) |-> !busy_o);
  // R10
  comm_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && err_o == 2'd1) |-> (cfg_cs_no && !sh_act));
endmodule

// File: tb/cfg_loader_tb_top.sv
module cfg_loader_tb_top;
  typedef struct packed {
    logic [7:0]  n;
    logic        early;
    logic        late;
    logic [7:0]  stall;
    logic        extra;
    logic [1:0]  eerr;
    logic [15:0] epost;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'd4, 1'b0, 1'b1, 8'hFF, 1'b0, 2'd0, 16'd208},
    '{8'd1, 1'b0, 1'b1, 8'hFF, 1'b0, 2'd0, 16'd208},
    '{8'd6, 1'b0, 1'b0, 8'hFF, 1'b0, 2'd3, 16'd104},
    '{8'd3, 1'b1, 1'b1, 8'hFF, 1'b0, 2'd2, 16'd0},
    '{8'd5, 1'b0, 1'b1, 8'd2,  1'b0, 2'd1, 16'd0},
    '{8'd7, 1'b0, 1'b1, 8'hFF, 1'b1, 2'd0, 16'd208}
  };
  localparam int RST_EXP = 25;
  localparam int CLR_EXP = 250;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, clr = 1'b0;
  logic [7:0] img_data;
  logic img_valid, img_last, img_ready, rst_no, cs_no, sclk, mosi, done, busy, ok;
  logic [1:0] err;
  int total = 0, bad = 0;

  int cur_v = 0, cur_n = 0, cur_stall = 255;
  logic cur_early = 1'b0, cur_late = 1'b0;
  int idx = 0;
  int rst_low, cs_bad, clr_cyc, pre, ones, post, rx_n, rx_bad, csfall, bits;
  logic [7:0] rx_byte;
  logic p_sclk, p_cs;

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(int v, int i);
    return 8'((v * 37) + (i * 29) + 8'hA5);
  endfunction

  assign img_valid = (idx < cur_n) && (idx != cur_stall);
  assign img_data  = pat(cur_v, idx);
  assign img_last  = (idx == cur_n - 1);
  assign done      = (cur_n != 0 && rx_n >= cur_n) ? cur_late : cur_early;

  cfg_loader #(.CLEAR_NS(2000)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .img_data_i(img_data), .img_valid_i(img_valid), .img_last_i(img_last),
    .img_ready_o(img_ready), .cfg_rst_no(rst_no), .cfg_cs_no(cs_no),
    .cfg_sclk_o(sclk), .cfg_mosi_o(mosi), .cfg_done_i(done),
    .busy_o(busy), .ok_o(ok), .err_o(err)
  );

  always @(posedge clk) begin
    if (clr) idx <= 0;
    else if (img_valid && img_ready) idx <= idx + 1;
  end

  // target-side monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (clr) begin
      rst_low = 0; cs_bad = 0; clr_cyc = 0; pre = 0; ones = 0; post = 0;
      rx_n = 0; rx_bad = 0; csfall = 0; bits = 0; rx_byte = 0;
    end else begin
      if (!rst_no) rst_low++;
      if (!rst_no && cs_no) cs_bad++;
      if (rst_no && !cs_no && pre == 0 && rx_n == 0 && bits == 0) clr_cyc++;
      if (!cs_no && p_cs) csfall++;
      if (sclk && !p_sclk) begin
        if (!cs_no) begin
          rx_byte = {rx_byte[6:0], mosi};
          bits++;
          if (bits == 8) begin
            if (rx_byte != pat(cur_v, rx_n)) rx_bad++;
            rx_n++; bits = 0;
          end
        end else begin
          if (mosi) ones++;
          if (rx_n == 0 && bits == 0) pre++;
          else post++;
        end
      end
    end
    p_sclk = sclk; p_cs = cs_no;
  end

  task automatic chk(input bit c, input string req, input int act, input int exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic run(input int v);
    vec_t t;
    int exp_rx, exp_pre, exp_fall, w;
    t = VECS[v];
    @(posedge clk); #1;
    clr = 1'b1; cur_v = v; cur_n = int'(t.n); cur_stall = int'(t.stall);
    cur_early = t.early; cur_late = t.late;
    @(posedge clk); #1 clr = 1'b0;
    pulse_start();
    @(negedge clk);
    // R11: start clears held status
    chk(busy && !ok && err == 2'd0, "R11 start clears", {29'd0, ok, err}, 0);
    if (t.extra) begin
      repeat (500) @(posedge clk);
      #1 start = 1'b1; @(posedge clk); #1 start = 1'b0;
    end
    w = 0;
    while (busy && w < 20000) begin @(negedge clk); w++; end
    chk(w < 20000, "R1 run ends", w, 0);
    exp_rx   = (t.eerr == 2'd2) ? 0 : (t.stall != 8'hFF) ? int'(t.stall) : int'(t.n);
    exp_pre  = (t.eerr == 2'd2) ? 0 : 8;
    exp_fall = (t.eerr == 2'd2) ? 1 : 2;
    chk(err == t.eerr, "R4 R8 R10 error code", err, t.eerr);
    chk(ok == (t.eerr == 2'd0), "R9 ok flag", ok, t.eerr == 2'd0);
    chk(rst_low >= RST_EXP && rst_low <= RST_EXP + 1, "R2 reset low", rst_low, RST_EXP);
    chk(cs_bad == 0, "R2 cs low with reset", cs_bad, 0);
    chk(clr_cyc >= CLR_EXP && clr_cyc <= CLR_EXP + 2, "R3 clear wait", clr_cyc, CLR_EXP);
    chk(pre == exp_pre, "R5 pre clocks", pre, exp_pre);
    chk(ones == 0, "R5 R7 dummy mosi", ones, 0);
    chk(rx_n == exp_rx, "R6 image bytes", rx_n, exp_rx);
    chk(rx_bad == 0, "R6 byte content", rx_bad, 0);
    chk(post == int'(t.epost), "R7 R9 trailing clocks", post, t.epost);
    chk(csfall == exp_fall, "R6 cs periods", csfall, exp_fall);
    chk(cs_no && rst_no && !sclk, "R10 R1 idle pins", {cs_no, rst_no, sclk}, 6);
    repeat (20) @(negedge clk);
    chk(err == t.eerr && ok == (t.eerr == 2'd0) && post == int'(t.epost),
        "R11 status held", {ok, err}, t.eerr);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clr = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1 clr = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rst_no && cs_no && !sclk && !img_ready, "R1 pins", {rst_no, cs_no, sclk, img_ready}, 12);
    chk(!busy && !ok && err == 2'd0, "R1 status", {busy, ok, err}, 0);
    for (int v = 0; v < NV; v++) run(v);
    // R11: error from stall held, then a success clears it
    run(4);
    run(0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule